// File: doc/BRIEF.md
# Maintenance Address Translation Window Bank

This block holds a bank of programmable address-mapping windows used when a local bus access must become an outgoing maintenance transaction. Software configures each window through a 32-bit register port: a base and a mask that select a slice of the local address space, an enable, a 24-bit maintenance offset, and the routing attributes the transaction carries: a 16-bit destination ID, a hop count and a priority.

The lookup port takes a 32-bit local address together with a request strobe. One cycle later it reports a hit or a miss. On a hit it also returns the winning window number, the translated 24-bit maintenance offset and that window's routing fields. When more than one window claims the address, the lowest-numbered window wins. Illegal priority writes are coerced as they are stored. Reserved bits cannot be written and always read as zero.

Top module: `mtw_xlate_top`

## Requirements
- R1: Window n occupies byte addresses REG_BASE + 0x10*n (default REG_BASE = 0x10100). Its base word is at +0x0, mask at +0x4, offset at +0x8 and control at +0xC. A read strobe loads cfg_rdata with the addressed word on the next clock edge. Addresses outside the map read as zero, and writes to them change no register.
- R2: After reset every window reads base 0, mask 0 (enable 0), offset 0 and control 0x0000FF00. The hop count field is 0xFF and every other field is zero.
- R3: Reserved bits read as zero whatever was written: base bits [2:0], mask bits [1:0], offset bits [31:24] and control bits [5:0].
- R4: The priority field is control bits [7:6]. A write of 2'b11 is stored as 2'b10, and any other value is stored unchanged. A hit never reports priority 2'b11.
- R5: Control bits [31:24] hold the upper destination ID byte and are writable only when WIDE_ID = 1. With WIDE_ID = 0 they read as zero. Control bits [23:16] hold the lower byte and bits [15:8] the hop count.
- R6: A window whose enable (mask bit 2) is 0 never hits.
- R7: An enabled window hits when address bits [31:3] and base bits [31:3] are equal wherever mask bits [31:3] are 1.
- R8: On a hit, lk_offset = (window offset + (address AND NOT mask')) mod 2^24, where mask' is the mask with bits [2:0] cleared.
- R9: When several enabled windows hit, the lowest-numbered one is reported. lk_win, lk_dest_id ({upper byte, lower byte}), lk_hops and lk_prio come from that window.
- R10: The lookup result appears on the clock edge after lk_req is sampled high. Exactly one of lk_hit and lk_miss is then high. After an edge where lk_req was low, both are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_wr | input | 1 | Register write strobe |
| cfg_rd | input | 1 | Register read strobe |
| cfg_addr | input | 32 | Register byte address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data, valid the cycle after cfg_rd |
| lk_req | input | 1 | Lookup request |
| lk_addr | input | 32 | Local address to translate |
| lk_hit | output | 1 | Lookup hit |
| lk_miss | output | 1 | Lookup miss |
| lk_win | output | IDX_W | Winning window number |
| lk_offset | output | 24 | Translated maintenance offset |
| lk_dest_id | output | 16 | Destination ID of winning window |
| lk_hops | output | 8 | Hop count of winning window |
| lk_prio | output | 2 | Priority of winning window |

## Verification
Both results take exactly one register stage. Read data is due on the first rising edge after cfg_rd is sampled high, and a lookup result on the first rising edge after lk_req is sampled high. The bench drives every strobe at a falling edge and samples at the next falling edge, half a cycle after the edge that loads the result. It drops the strobe before the following edge, so the idle state of the lookup flags is observed one cycle later in the same way. A write takes effect on its own edge, so every read or lookup issued after it sees the new value.

// File: rtl/mtw_pkg.sv
package mtw_pkg;

  typedef struct packed {
    logic [28:0] base;    // address bits [31:3]
    logic [28:0] mask;    // mask bits [31:3]
    logic        en;
    logic [23:0] ofs;
    logic [7:0]  did_hi;
    logic [7:0]  did_lo;
    logic [7:0]  hops;
    logic [1:0]  prio;
  } win_cfg_t;

  typedef enum logic [1:0] {
    SEL_BASE = 2'd0,
    SEL_MASK = 2'd1,
    SEL_OFS  = 2'd2,
    SEL_CTRL = 2'd3
  } reg_sel_e;

  localparam win_cfg_t WIN_RST = '{base: '0, mask: '0, en: 1'b0, ofs: '0,
                                   did_hi: '0, did_lo: '0, hops: 8'hFF,
                                   prio: '0};

  function automatic logic [1:0] legal_prio(input logic [1:0] p);
    return (p == 2'b11) ? 2'b10 : p;
  endfunction

endpackage

// File: rtl/mtw_regfile.sv
module mtw_regfile
  import mtw_pkg::*;
#(
  parameter int          NUM_WIN  = 16,
  parameter logic [31:0] REG_BASE = 32'h0001_0100,
  parameter bit          WIDE_ID  = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr,
  input  logic        cfg_rd,
  input  logic [31:0] cfg_addr,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  output win_cfg_t    cfg_o [NUM_WIN]
);

  localparam int          IDX_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;
  localparam logic [31:0] SPAN  = 32'(NUM_WIN * 16);

  logic [31:0] rel;
  logic        in_map;
  logic [IDX_W-1:0] widx;
  reg_sel_e    rsel;
  win_cfg_t    cfg_q [NUM_WIN];
  win_cfg_t    cfg_d [NUM_WIN];
  logic [31:0] rd_word;
  logic [31:0] rdata_q, rdata_d;

  assign rel    = cfg_addr - REG_BASE;
  assign in_map = (rel < SPAN) && (rel[1:0] == 2'b00);
  assign widx   = rel[4 +: IDX_W];
  assign rsel   = reg_sel_e'(rel[3:2]);

  // next-state for the register bank
  always_comb begin
    for (int i = 0; i < NUM_WIN; i++) cfg_d[i] = cfg_q[i];
    if (cfg_wr && in_map) begin
      unique case (rsel)
        SEL_BASE: cfg_d[widx].base = cfg_wdata[31:3];
        SEL_MASK: begin
          cfg_d[widx].mask = cfg_wdata[31:3];
          cfg_d[widx].en   = cfg_wdata[2];
        end
        SEL_OFS:  cfg_d[widx].ofs = cfg_wdata[23:0];
        SEL_CTRL: begin
          if (WIDE_ID) cfg_d[widx].did_hi = cfg_wdata[31:24];
          cfg_d[widx].did_lo = cfg_wdata[23:16];
          cfg_d[widx].hops   = cfg_wdata[15:8];
          cfg_d[widx].prio   = legal_prio(cfg_wdata[7:6]);
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_WIN; i++) cfg_q[i] <= WIN_RST;
    end else begin
      for (int i = 0; i < NUM_WIN; i++) cfg_q[i] <= cfg_d[i];
    end
  end

  // read path
  always_comb begin
    rd_word = '0;
    if (in_map) begin
      unique case (rsel)
        SEL_BASE: rd_word = {cfg_q[widx].base, 3'b000};
        SEL_MASK: rd_word = {cfg_q[widx].mask, cfg_q[widx].en, 2'b00};
        SEL_OFS:  rd_word = {8'h00, cfg_q[widx].ofs};
        SEL_CTRL: rd_word = {cfg_q[widx].did_hi, cfg_q[widx].did_lo,
                             cfg_q[widx].hops, cfg_q[widx].prio, 6'b000000};
      endcase
    end
  end

  assign rdata_d = cfg_rd ? rd_word : rdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rdata_d;
  end

  assign cfg_rdata = rdata_q;
  assign cfg_o     = cfg_q;

endmodule

// File: rtl/mtw_match.sv
module mtw_match
  import mtw_pkg::*;
#(
  parameter int NUM_WIN = 16
) (
  input  logic [31:0]  lk_addr,
  input  win_cfg_t     cfg_i [NUM_WIN],
  output logic [NUM_WIN-1:0] hit_vec,
  output logic [23:0]  xofs [NUM_WIN]
);

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    logic [31:0] full_mask;
    logic [31:0] pass_bits;
    assign full_mask  = {cfg_i[w].mask, 3'b000};
    assign pass_bits  = lk_addr & ~full_mask;
    assign hit_vec[w] = cfg_i[w].en &&
                        (((lk_addr[31:3] ^ cfg_i[w].base) & cfg_i[w].mask) == '0);
    assign xofs[w]    = cfg_i[w].ofs + pass_bits[23:0];
  end

endmodule

// File: rtl/mtw_pick.sv
module mtw_pick
  import mtw_pkg::*;
#(
  parameter int NUM_WIN = 16,
  parameter int IDX_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lk_req,
  input  logic [NUM_WIN-1:0] hit_vec,
  input  logic [23:0]        xofs [NUM_WIN],
  input  win_cfg_t           cfg_i [NUM_WIN],
  output logic               lk_hit,
  output logic               lk_miss,
  output logic [IDX_W-1:0]   lk_win,
  output logic [23:0]        lk_offset,
  output logic [15:0]        lk_dest_id,
  output logic [7:0]         lk_hops,
  output logic [1:0]         lk_prio
);

  logic [IDX_W-1:0] sel;
  logic             any;
  logic             hit_d, miss_d;
  logic [IDX_W-1:0] win_d;
  logic [23:0]      ofs_d;
  logic [15:0]      did_d;
  logic [7:0]       hops_d;
  logic [1:0]       prio_d;

  // lowest index wins: scan from the top so the lowest hit is written last
  always_comb begin
    sel = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (hit_vec[i]) sel = IDX_W'(i);
    end
  end

  assign any = |hit_vec;

  always_comb begin
    hit_d  = lk_req & any;
    miss_d = lk_req & ~any;
    win_d  = lk_win;
    ofs_d  = lk_offset;
    did_d  = lk_dest_id;
    hops_d = lk_hops;
    prio_d = lk_prio;
    if (lk_req) begin
      win_d  = sel;
      ofs_d  = xofs[sel];
      did_d  = {cfg_i[sel].did_hi, cfg_i[sel].did_lo};
      hops_d = cfg_i[sel].hops;
      prio_d = cfg_i[sel].prio;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lk_hit     <= 1'b0;
      lk_miss    <= 1'b0;
      lk_win     <= '0;
      lk_offset  <= '0;
      lk_dest_id <= '0;
      lk_hops    <= '0;
      lk_prio    <= '0;
    end else begin
      lk_hit     <= hit_d;
      lk_miss    <= miss_d;
      lk_win     <= win_d;
      lk_offset  <= ofs_d;
      lk_dest_id <= did_d;
      lk_hops    <= hops_d;
      lk_prio    <= prio_d;
    end
  end

endmodule

// File: rtl/mtw_xlate_top.sv
module mtw_xlate_top
  import mtw_pkg::*;
#(
  parameter int          NUM_WIN  = 16,
  parameter logic [31:0] REG_BASE = 32'h0001_0100,
  parameter bit          WIDE_ID  = 1'b1,
  localparam int         IDX_W    = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic             cfg_rd,
  input  logic [31:0]      cfg_addr,
  input  logic [31:0]      cfg_wdata,
  output logic [31:0]      cfg_rdata,
  input  logic             lk_req,
  input  logic [31:0]      lk_addr,
  output logic             lk_hit,
  output logic             lk_miss,
  output logic [IDX_W-1:0] lk_win,
  output logic [23:0]      lk_offset,
  output logic [15:0]      lk_dest_id,
  output logic [7:0]       lk_hops,
  output logic [1:0]       lk_prio
);

  logic [1:0]         rst_pipe;
  logic               rst_s_n;
  win_cfg_t           cfg_w [NUM_WIN];
  logic [NUM_WIN-1:0] hit_vec;
  logic [23:0]        xofs [NUM_WIN];

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s_n = rst_pipe[1];

  mtw_regfile #(.NUM_WIN(NUM_WIN), .REG_BASE(REG_BASE), .WIDE_ID(WIDE_ID)) u_regs (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .cfg_wr    (cfg_wr),
    .cfg_rd    (cfg_rd),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .cfg_o     (cfg_w)
  );

  mtw_match #(.NUM_WIN(NUM_WIN)) u_match (
    .lk_addr (lk_addr),
    .cfg_i   (cfg_w),
    .hit_vec (hit_vec),
    .xofs    (xofs)
  );

  mtw_pick #(.NUM_WIN(NUM_WIN), .IDX_W(IDX_W)) u_pick (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .lk_req     (lk_req),
    .hit_vec    (hit_vec),
    .xofs       (xofs),
    .cfg_i      (cfg_w),
    .lk_hit     (lk_hit),
    .lk_miss    (lk_miss),
    .lk_win     (lk_win),
    .lk_offset  (lk_offset),
    .lk_dest_id (lk_dest_id),
    .lk_hops    (lk_hops),
    .lk_prio    (lk_prio)
  );

endmodule

// File: rtl/mtw_chk.sv
module mtw_chk (
  input logic        clk,
  input logic        rst_s_n,
  input logic        cfg_rd,
  input logic [31:0] cfg_addr,
  input logic [31:0] cfg_rdata,
  input logic        lk_req,
  input logic        lk_hit,
  input logic        lk_miss,
  input logic [1:0]  lk_prio
);

  // R10
  hit_miss_excl_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    !(lk_hit && lk_miss));

  // R10
  req_answer_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    lk_req |=> (lk_hit != lk_miss));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    !lk_req |=> (!lk_hit && !lk_miss));

  // R4
  prio_legal_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    lk_hit |-> (lk_prio != 2'b11));

  // R3
  rsv_base_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (cfg_rd && cfg_addr[3:0] == 4'h0) |=> (cfg_rdata[2:0] == 3'b000));

  // R3
  rsv_mask_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (cfg_rd && cfg_addr[3:0] == 4'h4) |=> (cfg_rdata[1:0] == 2'b00));

  // R3
  rsv_ofs_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (cfg_rd && cfg_addr[3:0] == 4'h8) |=> (cfg_rdata[31:24] == 8'h00));

  // R3
  rsv_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (cfg_rd && cfg_addr[3:0] == 4'hC) |=> (cfg_rdata[5:0] == 6'b000000));

endmodule

bind mtw_xlate_top mtw_chk u_chk (
  .clk       (clk),
  .rst_s_n   (rst_s_n),
  .cfg_rd    (cfg_rd),
  .cfg_addr  (cfg_addr),
  .cfg_rdata (cfg_rdata),
  .lk_req    (lk_req),
  .lk_hit    (lk_hit),
  .lk_miss   (lk_miss),
  .lk_prio   (lk_prio)
);

// File: tb/sim_mtw_xlate_top.sv
module sim_mtw_xlate_top;

  localparam int          NW    = 16;
  localparam logic [31:0] RBASE = 32'h0001_0100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0, cfg_rd = 1'b0;
  logic [31:0] cfg_addr = '0, cfg_wdata = '0;
  logic [31:0] cfg_rdata, u1_rdata;
  logic        lk_req = 1'b0;
  logic [31:0] lk_addr = '0;
  logic        lk_hit, lk_miss, u1_hit, u1_miss;
  logic [3:0]  lk_win, u1_win;
  logic [23:0] lk_offset, u1_offset;
  logic [15:0] lk_dest_id, u1_dest_id;
  logic [7:0]  lk_hops, u1_hops;
  logic [1:0]  lk_prio, u1_prio;

  int n_run = 0, n_fail = 0;

  // bench model of the stored words
  logic [31:0] m_base [NW];
  logic [31:0] m_mask [NW];
  logic [31:0] m_ofs  [NW];
  logic [31:0] m_ctl  [NW];

  always #2 clk = ~clk;

  mtw_xlate_top u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .lk_req(lk_req), .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_miss(lk_miss),
    .lk_win(lk_win), .lk_offset(lk_offset), .lk_dest_id(lk_dest_id),
    .lk_hops(lk_hops), .lk_prio(lk_prio)
  );

  mtw_xlate_top #(.WIDE_ID(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(u1_rdata),
    .lk_req(lk_req), .lk_addr(lk_addr), .lk_hit(u1_hit), .lk_miss(u1_miss),
    .lk_win(u1_win), .lk_offset(u1_offset), .lk_dest_id(u1_dest_id),
    .lk_hops(u1_hops), .lk_prio(u1_prio)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic rd(input logic [31:0] a, output logic [31:0] d0,
                    output logic [31:0] d1);
    @(negedge clk);
    cfg_rd = 1'b1; cfg_addr = a;
    @(negedge clk);
    cfg_rd = 1'b0;
    d0 = cfg_rdata; d1 = u1_rdata;
  endtask

  function automatic logic [31:0] waddr(input int w, input int r);
    return RBASE + 32'(w * 16) + 32'(r * 4);
  endfunction

  task automatic lookup(input logic [31:0] a);
    bit          e_hit = 1'b0;
    int          e_win = 0;
    logic [31:0] mk;
    logic [23:0] e_ofs = '0;
    for (int w = NW - 1; w >= 0; w--) begin
      mk = m_mask[w] & 32'hFFFF_FFF8;
      if (m_mask[w][2] && (((a ^ m_base[w]) & mk) == 0)) begin
        e_hit = 1'b1; e_win = w;
        e_ofs = m_ofs[w][23:0] + 24'(a & ~mk);
      end
    end
    @(negedge clk);
    lk_req = 1'b1; lk_addr = a;
    @(negedge clk);
    lk_req = 1'b0;
    // R10 one-cycle answer; R6/R7 hit decision
    check(lk_hit == e_hit && lk_miss == !e_hit, "R7", {30'b0, lk_hit, lk_miss},
          {30'b0, e_hit, !e_hit});
    if (e_hit) begin
      check(lk_win == 4'(e_win), "R9 win", 32'(lk_win), 32'(e_win));
      check(lk_offset == e_ofs, "R8", 32'(lk_offset), 32'(e_ofs));
      check(lk_dest_id == m_ctl[e_win][31:16], "R9 dest", 32'(lk_dest_id),
            32'(m_ctl[e_win][31:16]));
      check(lk_hops == m_ctl[e_win][15:8] && lk_prio == m_ctl[e_win][7:6],
            "R9 hops/prio", {22'b0, lk_hops, lk_prio},
            {22'b0, m_ctl[e_win][15:8], m_ctl[e_win][7:6]});
    end
  endtask

  initial begin
    logic [31:0] d0, d1, wd;
    logic [1:0]  p;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    check(!lk_hit && !lk_miss, "R10 reset idle", {30'b0, lk_hit, lk_miss}, 0);

    // R2: reset values of all registers
    for (int w = 0; w < NW; w++) begin
      for (int r = 0; r < 4; r++) begin
        rd(waddr(w, r), d0, d1);
        check(d0 == ((r == 3) ? 32'h0000_FF00 : 32'h0), "R2", d0,
              (r == 3) ? 32'h0000_FF00 : 32'h0);
      end
    end

    // R6: all windows disabled after reset
    lookup(32'h0);

    // program every window with reserved bits set (R3) and all priorities (R4)
    for (int w = 0; w < NW; w++) begin
      p  = 2'(w % 4);
      wd = (32'(w % 8) << 20) | 32'h7;
      wr(waddr(w, 0), wd); m_base[w] = wd & 32'hFFFF_FFF8;
      wd = ((w == 12) ? 32'hFFFF_0000 : 32'hFFF0_0000) |
           (((w % 8) == 2) ? 32'h3 : 32'h7);
      wr(waddr(w, 1), wd); m_mask[w] = wd & 32'hFFFF_FFFC;
      wd = 32'hFF00_0000 | 32'(w * 32'h11111) | 32'h00F0_0000;
      wr(waddr(w, 2), wd); m_ofs[w] = wd & 32'h00FF_FFFF;
      wd = {8'hA0 + 8'(w), 8'h10 + 8'(w), 8'h20 + 8'(w), p, 6'h3F};
      wr(waddr(w, 3), wd);
      m_ctl[w] = {wd[31:8], (p == 2'b11) ? 2'b10 : p, 6'h0};
    end

    // R1/R3/R4: read back all registers
    for (int w = 0; w < NW; w++) begin
      rd(waddr(w, 0), d0, d1); check(d0 == m_base[w], "R1 R3 base", d0, m_base[w]);
      rd(waddr(w, 1), d0, d1); check(d0 == m_mask[w], "R1 R3 mask", d0, m_mask[w]);
      rd(waddr(w, 2), d0, d1); check(d0 == m_ofs[w], "R1 R3 ofs", d0, m_ofs[w]);
      rd(waddr(w, 3), d0, d1); check(d0 == m_ctl[w], "R1 R4 ctrl", d0, m_ctl[w]);
      // R5: narrow-ID instance keeps the upper byte at zero
      check(d1 == {8'h00, m_ctl[w][23:0]}, "R5", d1, {8'h00, m_ctl[w][23:0]});
    end

    // R1: out-of-map access is harmless and reads zero
    wr(RBASE + 32'(NW * 16), 32'hFFFF_FFFF);
    wr(RBASE - 32'h4, 32'hFFFF_FFFF);
    rd(RBASE + 32'(NW * 16), d0, d1); check(d0 == 0, "R1 out of map", d0, 0);
    rd(RBASE - 32'h4, d0, d1); check(d0 == 0, "R1 out of map", d0, 0);
    rd(waddr(0, 0), d0, d1); check(d0 == m_base[0], "R1 no side effect", d0, m_base[0]);
    rd(waddr(NW - 1, 3), d0, d1);
    check(d0 == m_ctl[NW - 1], "R1 no side effect", d0, m_ctl[NW - 1]);

    // R6-R10: sweep regions, inner offsets and out-of-range addresses
    for (int reg_i = 0; reg_i < 10; reg_i++) begin
      for (int k = 0; k < 6; k++) begin
        lookup((32'(reg_i) << 20) + 32'(k * 32'h2_3457) + 32'(k));
      end
    end
    lookup(32'h8000_0000);
    lookup(32'h0040_0005);
    lookup(32'h0041_0003);

    // R10: idle cycle after a request leaves both flags low
    @(negedge clk);
    check(!lk_hit && !lk_miss, "R10 idle", {30'b0, lk_hit, lk_miss}, 0);

    // R6: disable window 1; region 1 then falls to window 9
    wr(waddr(1, 1), 32'hFFF0_0000); m_mask[1] = 32'hFFF0_0000;
    lookup(32'h0012_3456);
    // R6: disable window 9 too; region 1 misses
    wr(waddr(9, 1), 32'hFFF0_0000); m_mask[9] = 32'hFFF0_0000;
    lookup(32'h0012_3456);

    // R4: rewrite of priority 11 on window 0
    wr(waddr(0, 3), 32'h1234_56C0); m_ctl[0] = 32'h1234_5680;
    rd(waddr(0, 3), d0, d1); check(d0 == 32'h1234_5680, "R4", d0, 32'h1234_5680);
    lookup(32'h0000_0010);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #400000;
    n_run++; n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule